// File: doc/BRIEF.md
# Audio Interrupt Status Aggregator

This block gathers per-channel progress and fault signals from a multichannel audio processing core and folds them into one main interrupt status word plus two detail words: a per-channel overflow word and a GPIO status word. A host reads any of the three words through a strobe-and-address read port. Some reads have clearing side effects. A single registered interrupt line tells the host that an enabled main status bit is set.

The channel-wide bits are event driven. The lock bit records the moment every active channel's rate converter reports lock. The lock bit also drops by itself as soon as that condition is lost. The ramp-up, ramp-down and mute-done bits record the moment the last relevant channel finishes. Each GPIO pin passes through a two-flop synchronizer. Each pin has a polarity select, an edge-or-level mode and a summary mask. Edge pins and level pins clear by different rules.

Top module: `audio_irq_agg`

## Requirements
- R1: After reset, all three readable words and `irq` are 0. The address map is: 0 = main status, 1 = overflow status, 2 = GPIO status. In the main word, bit 0 = lock, bit 1 = ramp-up done, bit 2 = ramp-down done, bit 3 = mute done, bit 4 = overflow summary, bit 5 = GPIO summary. Upper bits read 0. `rd_data` shows the addressed word in the same cycle as the read.
- R2: The lock bit sets one clock after the condition "at least one channel active and every active channel locked" becomes true. Inactive channels are ignored. While the condition simply stays true, the bit does not set again.
- R3: When the lock condition is lost, the lock bit returns to 0 on the next clock, without any read.
- R4: The ramp-up bit sets one clock after every active channel reports ramp-up done. The ramp-down bit follows the same rule with the ramp-down done inputs.
- R5: The mute-done bit sets one clock after every muted channel reports mute done. Channels that are not muted are ignored.
- R6: A read of address 0 clears the lock, ramp-up, ramp-down and mute-done bits. If a new event for one of these bits arrives on the same clock as the read, the bit stays set.
- R7: Bit i of address 1 records a clip on channel i. A read of address 1 clears the word, so main bit 4 is 0 from the next cycle. A read of address 0 leaves the word intact.
- R8: Main bit 5 is the OR of the GPIO status bits whose mask bit is 0. A read of address 0 never clears it. A masked pin still records its status bit at address 2.
- R9: A pin in edge mode (`gpio_edge`=1) sets its status bit on a transition to its active level. The active level is high when `gpio_pol`=1 and low when `gpio_pol`=0. The bit appears three clocks after the input changes. A read of address 2 clears the bit.
- R10: A pin in level mode (`gpio_edge`=0) keeps its status bit set while the pin is at its active level, even across reads of address 2. Once the pin is inactive, a read of address 2 clears the bit.
- R11: `irq` is the OR of the main status bits ANDed with `irq_en`, registered one clock after the status word. It is low whenever no enabled bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_active | input | NUM_CH | Channel is active (used for lock and ramp conditions) |
| ch_muted | input | NUM_CH | Channel is muted (used for the mute condition) |
| src_locked | input | NUM_CH | Rate converter of the channel is locked |
| rampup_done | input | NUM_CH | Channel finished its ramp-up interval |
| rampdn_done | input | NUM_CH | Channel finished its ramp-down interval |
| mute_done | input | NUM_CH | Channel finished its mute cycle-down |
| clip_hit | input | NUM_CH | Output sample of the channel was clipped this cycle |
| gpio_in | input | NUM_GPIO | Asynchronous GPIO pins |
| gpio_pol | input | NUM_GPIO | 1 = active high or rising, 0 = active low or falling |
| gpio_edge | input | NUM_GPIO | 1 = edge mode, 0 = level mode |
| gpio_mask | input | NUM_GPIO | 1 = pin excluded from the GPIO summary bit |
| irq_en | input | 6 | Enable per main status bit for `irq` |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Word select for the read |
| rd_data | output | DATA_W | Addressed word |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The bench builds the block with its defaults: four channels, four GPIO pins and an 8-bit read word. Four channels are enough to keep two channels inactive or unmuted while the others switch, which shows that the reductions skip deselected channels. Four pins are enough to give each pin its own role at the same time: a rising-edge pin, a level pin, a masked pin and a falling-edge pin. Because of this, a clear on one pin can be checked for leaving the others untouched.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam int MAIN_W = 6;
  localparam int B_LOCK = 0;
  localparam int B_RUP  = 1;
  localparam int B_RDN  = 2;
  localparam int B_MUTE = 3;
  localparam int B_OVFL = 4;
  localparam int B_GPIO = 5;
  localparam int A_MAIN = 0;
  localparam int A_OVFL = 1;
  localparam int A_GPIO = 2;
endpackage

// File: rtl/aai_all_done.sv
// Reduces a per-channel flag over the selected channels and flags the
// cycle in which the reduced condition first becomes true.
module aai_all_done #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] done,
  output logic         cond,
  output logic         rise
);
  logic cond_q;

  always_comb begin
    cond = (|sel) & (&(done | ~sel));
    rise = cond & ~cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end
endmodule

// File: rtl/aai_sticky.sv
// Sticky status bit: set beats forced drop and read clear.
module aai_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic drop,
  input  logic rd_clr,
  output logic q
);
  logic q_d;

  always_comb begin
    if (set)                 q_d = 1'b1;
    else if (drop || rd_clr) q_d = 1'b0;
    else                     q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/aai_gpio_pin.sv
// One GPIO pin: synchronizer, polarity, edge or level capture.
module aai_gpio_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic edge_mode,
  input  logic rd_clr,
  output logic stat
);
  logic s1, s2, act, act_q, stat_d;

  always_comb begin
    act = pol ? s2 : ~s2;
    if (edge_mode) begin
      if (act && !act_q) stat_d = 1'b1;
      else if (rd_clr)   stat_d = 1'b0;
      else               stat_d = stat;
    end else begin
      if (act)           stat_d = 1'b1;
      else if (rd_clr)   stat_d = 1'b0;
      else               stat_d = stat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      act_q <= 1'b1;
      stat  <= 1'b0;
    end else begin
      s1    <= pin;
      s2    <= s1;
      act_q <= act;
      stat  <= stat_d;
    end
  end
endmodule

// File: rtl/audio_irq_agg.sv
module audio_irq_agg
  import aai_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_GPIO = 4,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_active,
  input  logic [NUM_CH-1:0]   ch_muted,
  input  logic [NUM_CH-1:0]   src_locked,
  input  logic [NUM_CH-1:0]   rampup_done,
  input  logic [NUM_CH-1:0]   rampdn_done,
  input  logic [NUM_CH-1:0]   mute_done,
  input  logic [NUM_CH-1:0]   clip_hit,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_GPIO-1:0] gpio_pol,
  input  logic [NUM_GPIO-1:0] gpio_edge,
  input  logic [NUM_GPIO-1:0] gpio_mask,
  input  logic [MAIN_W-1:0]   irq_en,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  logic rd_main, rd_ovfl, rd_gpio;
  logic lock_cond, lock_rise, rup_cond, rup_rise;
  logic rdn_cond, rdn_rise, mute_cond, mute_rise;
  logic lock_q, rup_q, rdn_q, mute_q;
  logic [NUM_CH-1:0]   ovfl_q, ovfl_d;
  logic [NUM_GPIO-1:0] gpio_stat;
  logic [MAIN_W-1:0]   main_stat;
  logic                irq_d;

  always_comb begin
    rd_main = rd_stb && (rd_addr == ADDR_W'(A_MAIN));
    rd_ovfl = rd_stb && (rd_addr == ADDR_W'(A_OVFL));
    rd_gpio = rd_stb && (rd_addr == ADDR_W'(A_GPIO));
  end

  aai_all_done #(.N(NUM_CH)) u_lock (.clk(clk), .rst_n(rst_n), .sel(ch_active),
    .done(src_locked),  .cond(lock_cond), .rise(lock_rise));
  aai_all_done #(.N(NUM_CH)) u_rup  (.clk(clk), .rst_n(rst_n), .sel(ch_active),
    .done(rampup_done), .cond(rup_cond),  .rise(rup_rise));
  aai_all_done #(.N(NUM_CH)) u_rdn  (.clk(clk), .rst_n(rst_n), .sel(ch_active),
    .done(rampdn_done), .cond(rdn_cond),  .rise(rdn_rise));
  aai_all_done #(.N(NUM_CH)) u_mute (.clk(clk), .rst_n(rst_n), .sel(ch_muted),
    .done(mute_done),   .cond(mute_cond), .rise(mute_rise));

  // lock also drops when the condition is lost
  aai_sticky u_lock_bit (.clk(clk), .rst_n(rst_n), .set(lock_rise),
    .drop(~lock_cond), .rd_clr(rd_main), .q(lock_q));
  aai_sticky u_rup_bit  (.clk(clk), .rst_n(rst_n), .set(rup_rise),
    .drop(1'b0), .rd_clr(rd_main), .q(rup_q));
  aai_sticky u_rdn_bit  (.clk(clk), .rst_n(rst_n), .set(rdn_rise),
    .drop(1'b0), .rd_clr(rd_main), .q(rdn_q));
  aai_sticky u_mute_bit (.clk(clk), .rst_n(rst_n), .set(mute_rise),
    .drop(1'b0), .rd_clr(rd_main), .q(mute_q));

  // per-channel overflow word, clip beats read clear
  always_comb begin
    ovfl_d = rd_ovfl ? clip_hit : (ovfl_q | clip_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovfl_q <= '0;
    else        ovfl_q <= ovfl_d;
  end

  generate
    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
      aai_gpio_pin u_pin (
        .clk(clk), .rst_n(rst_n), .pin(gpio_in[g]), .pol(gpio_pol[g]),
        .edge_mode(gpio_edge[g]), .rd_clr(rd_gpio), .stat(gpio_stat[g]));
    end
  endgenerate

  always_comb begin
    main_stat         = '0;
    main_stat[B_LOCK] = lock_q;
    main_stat[B_RUP]  = rup_q;
    main_stat[B_RDN]  = rdn_q;
    main_stat[B_MUTE] = mute_q;
    main_stat[B_OVFL] = |ovfl_q;
    main_stat[B_GPIO] = |(gpio_stat & ~gpio_mask);
    irq_d             = |(main_stat & irq_en);
  end

  always_comb begin
    case (int'(rd_addr))
      A_MAIN:  rd_data = DATA_W'(main_stat);
      A_OVFL:  rd_data = DATA_W'(ovfl_q);
      A_GPIO:  rd_data = DATA_W'(gpio_stat);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/audio_irq_agg_chk.sv
module audio_irq_agg_chk
  import aai_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_GPIO = 4,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_stb,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [NUM_CH-1:0]   clip_hit,
  input logic [NUM_CH-1:0]   ovfl_q,
  input logic [NUM_GPIO-1:0] gpio_mask,
  input logic [MAIN_W-1:0]   main_stat,
  input logic [MAIN_W-1:0]   irq_en,
  input logic                lock_cond,
  input logic                irq
);
  logic rd_main, rd_ovfl;
  always_comb begin
    rd_main = rd_stb && (rd_addr == ADDR_W'(A_MAIN));
    rd_ovfl = rd_stb && (rd_addr == ADDR_W'(A_OVFL));
  end

  assert_lock_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stat[B_LOCK] && !lock_cond) |=> !main_stat[B_LOCK]);

  assert_ramp_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stat[B_RUP] && !rd_main) |=> main_stat[B_RUP]);

  assert_clip_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clip_hit) |=> ((ovfl_q & $past(clip_hit)) == $past(clip_hit)));

  assert_ovfl_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ovfl |=> ((ovfl_q & $past(ovfl_q)) == $past(ovfl_q)));

  assert_gpio_survives_main_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main && main_stat[B_GPIO]) |=> (main_stat[B_GPIO] || !$stable(gpio_mask)));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_stat & irq_en) == '0) |=> !irq);
endmodule

bind audio_irq_agg audio_irq_agg_chk #(
  .NUM_CH(NUM_CH), .NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .clip_hit(clip_hit), .ovfl_q(ovfl_q), .gpio_mask(gpio_mask),
  .main_stat(main_stat), .irq_en(irq_en), .lock_cond(lock_cond), .irq(irq)
);

// File: tb/audio_irq_agg_bench.sv
module audio_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NG  = 4;

  typedef struct {
    int    addr;
    int    exp;
    string tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NCH-1:0] ch_active, ch_muted, src_locked, rampup_done, rampdn_done, mute_done, clip_hit;
  logic [NG-1:0]  gpio_in, gpio_pol, gpio_edge, gpio_mask;
  logic [5:0]     irq_en;
  logic           rd_stb;
  logic [1:0]     rd_addr;
  logic [7:0]     rd_data;
  logic           irq;

  rd_item_t exp_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_agg u_audio_irq_agg (
    .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .ch_muted(ch_muted),
    .src_locked(src_locked), .rampup_done(rampup_done), .rampdn_done(rampdn_done),
    .mute_done(mute_done), .clip_hit(clip_hit), .gpio_in(gpio_in),
    .gpio_pol(gpio_pol), .gpio_edge(gpio_edge), .gpio_mask(gpio_mask),
    .irq_en(irq_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one read lasting one cycle, expected value queued
  task automatic do_read(input int addr, input int exp, input string tag);
    rd_item_t it;
    it.addr = addr; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    rd_stb  = 1'b1;
    rd_addr = 2'(addr);
    @(negedge clk);
    rd_stb  = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_checks++;
    if (irq !== exp) begin
      n_errors++;
      $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  // monitor: samples reads a quarter period after the driving edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rd_stb === 1'b1) begin
      rd_item_t it;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL scoreboard: unexpected read, actual=%0h expected=none", rd_data);
      end else begin
        it = exp_q.pop_front();
        if (rd_data !== 8'(it.exp)) begin
          n_errors++;
          $display("FAIL %s addr %0d: actual=%02h expected=%02h", it.tag, it.addr, rd_data, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ch_active = '0; ch_muted = '0; src_locked = '0; rampup_done = '0;
    rampdn_done = '0; mute_done = '0; clip_hit = '0;
    gpio_in = 4'b1000; gpio_pol = 4'b0111; gpio_edge = 4'b1101; gpio_mask = '0;
    irq_en = 6'h3F; rd_stb = 1'b0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk_irq(1'b0, "R1");
    do_read(0, 8'h00, "R1");
    do_read(1, 8'h00, "R1");
    do_read(2, 8'h00, "R1");

    // R2 lock on active channels only
    ch_active = 4'b0011; src_locked = 4'b0001;
    step(2);
    do_read(0, 8'h00, "R2");
    src_locked = 4'b0011;
    step(1);
    chk_irq(1'b0, "R11");
    step(1);
    chk_irq(1'b1, "R11");
    do_read(0, 8'h01, "R2");
    do_read(0, 8'h00, "R2");
    chk_irq(1'b0, "R11");

    // R3 unlock clears without read
    src_locked = 4'b0000; step(1);
    src_locked = 4'b0011; step(1);
    src_locked = 4'b0001; step(1);
    chk_irq(1'b1, "R3");
    do_read(0, 8'h00, "R3");

    // R6 event on the clock of the read wins
    src_locked = 4'b0011;
    do_read(0, 8'h00, "R6");
    do_read(0, 8'h01, "R6");
    do_read(0, 8'h00, "R6");

    // R4 ramp up / down
    rampup_done = 4'b0001; step(1);
    do_read(0, 8'h00, "R4");
    rampup_done = 4'b0011; step(1);
    do_read(0, 8'h02, "R4");
    do_read(0, 8'h00, "R6");
    rampdn_done = 4'b0011; step(1);
    do_read(0, 8'h04, "R4");
    rampup_done = '0; rampdn_done = '0;

    // R5 mute over muted channels
    ch_muted = 4'b0110; mute_done = 4'b0100; step(1);
    do_read(0, 8'h00, "R5");
    mute_done = 4'b0110; step(1);
    do_read(0, 8'h08, "R5");
    ch_muted = '0; mute_done = '0;

    // R7 overflow word
    clip_hit = 4'b0100; step(1);
    clip_hit = '0;
    do_read(0, 8'h10, "R7");
    chk_irq(1'b1, "R11");
    do_read(1, 8'h04, "R7");
    do_read(0, 8'h00, "R7");
    chk_irq(1'b0, "R11");

    // R11 enables gate irq
    irq_en = 6'h00;
    clip_hit = 4'b1000; step(1);
    clip_hit = '0; step(2);
    chk_irq(1'b0, "R11");
    do_read(0, 8'h10, "R11");
    do_read(1, 8'h08, "R7");
    irq_en = 6'h3F;

    // R9 rising edge pin 0, three-clock latency; R8 main read keeps it
    gpio_in[0] = 1'b1; step(2);
    do_read(2, 8'h00, "R9");
    do_read(0, 8'h20, "R8");
    do_read(0, 8'h20, "R8");
    do_read(2, 8'h01, "R9");
    do_read(2, 8'h00, "R9");
    do_read(0, 8'h00, "R8");

    // R10 level pin 1
    gpio_in[1] = 1'b1; step(3);
    do_read(2, 8'h02, "R10");
    do_read(2, 8'h02, "R10");
    gpio_in[1] = 1'b0; step(3);
    do_read(2, 8'h02, "R10");
    do_read(2, 8'h00, "R10");

    // R8 masked pin 2 recorded but not summarised
    gpio_mask = 4'b0100;
    gpio_in[2] = 1'b1; step(3);
    do_read(0, 8'h00, "R8");
    do_read(2, 8'h04, "R8");
    do_read(2, 8'h00, "R8");

    // R9 falling edge pin 3, rising ignored
    gpio_in[3] = 1'b0; step(3);
    do_read(2, 8'h08, "R9");
    gpio_in[3] = 1'b1; step(3);
    do_read(2, 8'h00, "R9");

    step(2);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard R1: actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule